// File: doc/BRIEF.md
# Four-Channel Timer Interrupt Prioritizer

This block holds four independent down-counters. Each counter has its own stored reload value and its own interrupt source. A counter that passes through zero puts a single-cycle pulse on its zero-count output. If interrupts are enabled for that channel, it also raises a pending request. The four requests share one interrupt line and one vector output, and a fixed priority orders them: channel 0 is the most urgent and channel 3 the least.

A processor-side write port sets the base vector, the interrupt-enable bit of each channel and the reload values. An acknowledge strobe picks the most urgent pending channel and moves it into service. It also latches a vector formed from the base and the channel number. A return strobe ends the service of the most urgent in-service channel. A priority input and a priority output let the block sit in a chain with other interrupt sources.

Top module: `quad_timer_irq`

## Requirements
- R1: After reset, irq is 0, zc is 0, vec is 0x00, the base vector is 0x00, no channel is pending or in service, and no counter runs until its reload value is written.
- R2: A write of value N to address c (c = 0..3) stores N for channel c and restarts its counter. The channel's zc output is then high exactly N, 2N, 3N, ... clock edges after the write edge. A stored value of 0 means 256 counts.
- R3: A zc pulse occurs whether or not interrupts are enabled. The channel becomes pending on that edge only if bit 0 of its mode, written at address 4+c, is 1.
- R4: When ack is high on an edge, the lowest-numbered pending channel k moves from pending to in service, and vec becomes (base + 2*k) mod 256 from that edge on. The base is written at address 8.
- R5: When ack is high and no channel is pending, vec becomes the base vector and no pending or in-service flag changes.
- R6: irq is high exactly when prio_in is high and some channel c is pending while no channel numbered c or lower is in service.
- R7: When reti is high on an edge, only the in-service flag of the lowest-numbered in-service channel is cleared.
- R8: prio_out is high only when prio_in is high and no channel is pending or in service.
- R9: Writes to addresses 9 to 15 change no state. The base vector, the counters and the modes are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 4 | 0..3 reload value, 4..7 mode, 8 base vector |
| wr_data | input | 8 | Write data |
| ack | input | 1 | Interrupt acknowledge strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| prio_in | input | 1 | Priority enable from the upstream source |
| irq | output | 1 | Interrupt request, active high |
| prio_out | output | 1 | Priority enable to the downstream source |
| zc | output | 4 | One zero-count pulse per channel |
| vec | output | 8 | Vector latched on the last acknowledge |

## Verification
The assertions check these rules on every cycle:
- an in-service channel 0 blocks irq,
- any activity pulls prio_out low,
- a pending flag only appears together with its zc pulse,
- an acknowledge moves channel 0 into service,
- an idle acknowledge returns the base,
- a return clears only the lowest in-service flag.

Only the bench's scenarios can show the counting period, the 256-count case for a zero reload value, the wrap of the vector sum and the blocking of a lower channel by a higher one in service. The bench shows these by comparing against its reference model over directed and random sequences of acknowledge, return and writes.

// File: rtl/qt_pkg.sv
package qt_pkg;
  localparam int QT_NCH = 4;
  localparam int QT_CW  = 8;

  typedef logic [QT_CW-1:0] byte_t;
  typedef logic [QT_CW:0]   cnt_t;

  // Reload count for a stored value; zero stands for the full range.
  function automatic cnt_t reload_value(byte_t tc);
    return (tc == '0) ? (cnt_t'(1) << QT_CW) : {1'b0, tc};
  endfunction

  // Vector for a channel: base plus twice the channel number, wrapping.
  function automatic byte_t vector_for(byte_t base, int unsigned ch);
    return base + byte_t'(ch << 1);
  endfunction
endpackage

// File: rtl/qt_channel.sv
module qt_channel
  import qt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tc_wr,
  input  logic  mode_wr,
  input  byte_t wr_data,
  output logic  zc,
  output logic  evt
);
  byte_t tc_q;
  cnt_t  cnt_q;
  logic  run_q;
  logic  ie_q;
  logic  hit;

  // Counter sits at its last count and no reload write overrides it.
  assign hit = run_q && (cnt_q == cnt_t'(1)) && !tc_wr;
  assign evt = hit && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      ie_q  <= 1'b0;
      zc    <= 1'b0;
    end else begin
      zc <= hit;
      if (mode_wr) ie_q <= wr_data[0];
      if (tc_wr) begin
        tc_q  <= wr_data;
        cnt_q <= reload_value(wr_data);
        run_q <= 1'b1;
      end else if (hit) begin
        cnt_q <= reload_value(tc_q);
      end else if (run_q) begin
        cnt_q <= cnt_q - cnt_t'(1);
      end
    end
  end
endmodule

// File: rtl/qt_arbiter.sv
module qt_arbiter #(
  parameter int NCH = 4,
  parameter int IW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ack,
  input  logic           reti,
  input  logic           prio_in,
  input  logic [NCH-1:0] evt,
  output logic [NCH-1:0] pend,
  output logic [NCH-1:0] ins,
  output logic           sel_valid,
  output logic [IW-1:0]  sel_idx,
  output logic           irq,
  output logic           prio_out
);
  logic [NCH-1:0] ack_oh;
  logic [NCH-1:0] reti_oh;
  logic           req_any;

  // Lowest-numbered pending channel wins the acknowledge.
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel_valid = 1'b1;
        sel_idx   = IW'(i);
      end
    end
  end

  // Lowest-numbered in-service channel is the one a return ends.
  always_comb begin
    reti_oh = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ins[i]) reti_oh = NCH'(1) << i;
    end
    if (!reti) reti_oh = '0;
  end

  assign ack_oh = (ack && sel_valid) ? (NCH'(1) << sel_idx) : '0;

  // A request counts only with nothing of equal or higher rank in service.
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    req_any = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      blocked = blocked | ins[i];
      if (pend[i] && !blocked) req_any = 1'b1;
    end
  end

  assign irq      = prio_in && req_any;
  assign prio_out = prio_in && (pend == '0) && (ins == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ins  <= '0;
    end else begin
      pend <= (pend & ~ack_oh) | evt;
      ins  <= (ins | ack_oh) & ~reti_oh;
    end
  end
endmodule

// File: rtl/quad_timer_irq.sv
module quad_timer_irq
  import qt_pkg::*;
#(
  parameter int NCH = QT_NCH,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [QT_CW-1:0]  wr_data,
  input  logic              ack,
  input  logic              reti,
  input  logic              prio_in,
  output logic              irq,
  output logic              prio_out,
  output logic [NCH-1:0]    zc,
  output logic [QT_CW-1:0]  vec
);
  localparam int IW        = $clog2(NCH);
  localparam int MODE_BASE = NCH;
  localparam int VEC_ADDR  = 2 * NCH;

  logic [NCH-1:0] tc_wr;
  logic [NCH-1:0] mode_wr;
  logic [NCH-1:0] evt;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] ins;
  logic           sel_valid;
  logic [IW-1:0]  sel_idx;
  logic           base_wr;
  byte_t          base_q;
  byte_t          vec_q;

  assign base_wr = wr_en && (wr_addr == AW'(VEC_ADDR));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign tc_wr[c]   = wr_en && (wr_addr == AW'(c));
    assign mode_wr[c] = wr_en && (wr_addr == AW'(MODE_BASE + c));

    qt_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tc_wr   (tc_wr[c]),
      .mode_wr (mode_wr[c]),
      .wr_data (wr_data),
      .zc      (zc[c]),
      .evt     (evt[c])
    );
  end

  qt_arbiter #(.NCH(NCH), .IW(IW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .reti      (reti),
    .prio_in   (prio_in),
    .evt       (evt),
    .pend      (pend),
    .ins       (ins),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .irq       (irq),
    .prio_out  (prio_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      vec_q  <= '0;
    end else begin
      if (base_wr) base_q <= wr_data;
      if (ack) vec_q <= sel_valid ? vector_for(base_q, 32'(sel_idx)) : base_q;
    end
  end

  assign vec = vec_q;
endmodule

// File: rtl/qt_checker.sv
module qt_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ack,
  input logic           reti,
  input logic           irq,
  input logic           prio_out,
  input logic [NCH-1:0] zc,
  input logic [7:0]     vec,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] ins,
  input logic [7:0]     base_q
);
  // R6: channel 0 in service masks every request
  a_r6_blocked_by_top: assert property (@(posedge clk) disable iff (!rst_n)
    ins[0] |-> !irq);

  // R8: any pending or in-service flag pulls the chain output low
  a_r8_chain_out: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend != '0) || (ins != '0)) |-> !prio_out);

  // R4: acknowledge with channel 0 pending puts it in service
  a_r4_ack_to_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !reti && pend[0]) |=> ins[0]);

  // R5: idle acknowledge returns the base vector
  a_r5_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (pend == '0)) |=> (vec == $past(base_q)));

  // R7: return ends service of channel 0 when it is in service
  a_r7_reti_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && ins[0]) |=> !ins[0]);

  // R7: the next in-service channel is left alone
  a_r7_reti_keeps_next: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && ins[0] && ins[1]) |=> ins[1]);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R3: a new pending flag always comes with its zero-count pulse
    a_r3_pend_from_zc: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> zc[i]);
  end
endmodule

bind quad_timer_irq qt_checker #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .reti     (reti),
  .irq      (irq),
  .prio_out (prio_out),
  .zc       (zc),
  .vec      (vec),
  .pend     (pend),
  .ins      (ins),
  .base_q   (base_q)
);

// File: tb/quad_timer_irq_test.sv
`timescale 1ns/1ps
module quad_timer_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ack = 1'b0;
  logic       reti = 1'b0;
  logic       prio_in = 1'b1;
  logic       irq, prio_out;
  logic [3:0] zc;
  logic [7:0] vec;

  int checks = 0;
  int fails = 0;
  string phase = "R1";
  bit started = 1'b0;

  always #4 clk = ~clk;

  quad_timer_irq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack(ack), .reti(reti), .prio_in(prio_in),
    .irq(irq), .prio_out(prio_out), .zc(zc), .vec(vec)
  );

  // Reference model state
  int m_cnt[4];
  int m_tc[4];
  bit m_run[4];
  bit m_ie[4];
  bit [3:0] m_pend, m_ins, m_zc;
  int m_base, m_vec;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_irq();
    bit blk = 1'b0;
    bit req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      blk = blk | m_ins[i];
      if (m_pend[i] && !blk) req = 1'b1;
    end
    return prio_in && req;
  endfunction

  always @(posedge clk) begin : model
    int a;
    int r;
    bit [3:0] ev;
    bit [3:0] zn;
    a = -1;
    r = -1;
    ev = '0;
    zn = '0;
    started <= 1'b1;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_cnt[i] = 0; m_tc[i] = 256; m_run[i] = 0; m_ie[i] = 0;
      end
      m_pend = '0; m_ins = '0; m_zc = '0; m_base = 0; m_vec = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        zn[i] = m_run[i] && (m_cnt[i] == 1) && !(wr_en && wr_addr == 4'(i));
        ev[i] = zn[i] && m_ie[i];
      end
      for (int i = 3; i >= 0; i--) begin
        if (m_pend[i]) a = i;
        if (m_ins[i]) r = i;
      end
      if (ack) m_vec = (a >= 0) ? ((m_base + 2 * a) % 256) : m_base;
      for (int i = 0; i < 4; i++) begin
        if (wr_en && wr_addr == 4'(i)) begin
          m_tc[i] = (wr_data == 0) ? 256 : int'(wr_data);
          m_cnt[i] = m_tc[i];
          m_run[i] = 1'b1;
        end else if (zn[i]) begin
          m_cnt[i] = m_tc[i];
        end else if (m_run[i]) begin
          m_cnt[i] = m_cnt[i] - 1;
        end
        if (wr_en && wr_addr == 4'(4 + i)) m_ie[i] = wr_data[0];
      end
      if (wr_en && wr_addr == 4'd8) m_base = int'(wr_data);
      if (ack && a >= 0) begin
        m_pend[a] = 1'b0;
        m_ins[a] = 1'b1;
      end
      if (reti && r >= 0) m_ins[r] = 1'b0;
      m_pend = m_pend | ev;
      m_zc = zn;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk({phase, " irq"}, int'(irq), int'(model_irq()));
      chk({phase, " prio_out"}, int'(prio_out),
          int'(prio_in && m_pend == 0 && m_ins == 0));
      chk({phase, " zc"}, int'(zc), int'(m_zc));
      chk({phase, " vec"}, int'(vec), m_vec);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    phase = "R1";
    repeat (10) tick();
    chk("R1 reset vec", int'(vec), 0);
    chk("R1 reset zc", int'(zc), 0);
    chk("R1 reset irq", int'(irq), 0);

    phase = "R5";
    wr(8, 8'hFC);
    pulse_ack();
    chk("R5 idle ack vec", int'(vec), 8'hFC);

    phase = "R9";
    for (int a = 9; a < 16; a++) wr(a, 8'hFF);
    repeat (5) tick();
    chk("R9 no counter started", int'(zc), 0);
    pulse_ack();
    chk("R9 base unchanged", int'(vec), 8'hFC);

    phase = "R2";
    wr(0, 4);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (zc[0]) n++;
    end
    chk("R2 period four pulses", n, 5);
    chk("R3 no pend without enable", int'(irq), 0);

    phase = "R3";
    wr(6, 1);
    wr(2, 0);
    n = 0;
    for (int k = 0; k < 255; k++) begin
      tick();
      if (zc[2]) n++;
    end
    chk("R2 zero reload not yet", n, 0);
    tick();
    chk("R2 zero reload is 256", int'(zc[2]), 1);
    chk("R3 pend with enable", int'(irq), 1);

    phase = "R4";
    pulse_ack();
    chk("R4 vec wraps for ch2", int'(vec), 8'h00);

    phase = "R6";
    wr(7, 1);
    wr(3, 3);
    repeat (5) tick();
    chk("R6 ch3 blocked by ch2 in service", int'(irq), 0);
    chk("R8 chain out low", int'(prio_out), 0);
    wr(5, 1);
    wr(1, 7);
    repeat (8) tick();
    chk("R6 ch1 outranks ch2 in service", int'(irq), 1);
    phase = "R4";
    pulse_ack();
    chk("R4 vec for ch1", int'(vec), 8'hFE);

    phase = "R7";
    pulse_reti();
    repeat (4) tick();
    pulse_reti();
    repeat (4) tick();

    phase = "R8";
    prio_in = 1'b0;
    repeat (3) tick();
    chk("R8 chain blocked upstream", int'(prio_out), 0);
    chk("R6 irq gated by prio_in", int'(irq), 0);
    prio_in = 1'b1;

    phase = "R6";
    for (int k = 0; k < 3000; k++) begin
      ack  = ($urandom_range(7) == 0);
      reti = ($urandom_range(5) == 0);
      if ($urandom_range(15) == 0) prio_in = ~prio_in;
      if ($urandom_range(63) == 0) begin
        wr_en = 1'b1;
        wr_addr = 4'($urandom_range(8));
        wr_data = 8'($urandom_range(9));
      end
      tick();
      ack = 1'b0; reti = 1'b0; wr_en = 1'b0;
    end
    prio_in = 1'b1;
    repeat (4) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule